// File: doc/BRIEF.md
# Sample-stamped timestamp counter unit

This block keeps a 64-bit time base that advances once per microsecond. A divider turns the system clock into microsecond ticks. Software reads the time base as two 32-bit words, low and high. The block also keeps one sample counter per audio channel. Each counter advances by one for every sample the channel transfers, as signalled on a per-channel strobe.

Each channel also has a stamp register. When a channel's sample counter is read, the same clock edge copies the live low time word into that stamp register. The sample count and the time at which it was taken therefore form a consistent pair. The stamp holds still until the channel's counter is read again.

To build a full 64-bit stamp, software reads the high word, then the channel's sample counter and stamp, then the high word again. If the two high-word reads differ, it repeats the sequence.

Top module: `ts_stamp_unit`

## Requirements
- R1: After synchronous reset the time base equals parameter UST_INIT (default zero), every sample counter and stamp register is zero, and rd_data is zero.
- R2: While us_tick_en is high, the time base increases by exactly one once every CLK_PER_US clock edges. While us_tick_en is low, the divider and the time base hold their values.
- R3: When the low time word steps from 32'hFFFFFFFF to zero, the high word increases by one at the same edge.
- R4: A read with rd_en high is returned on rd_data one edge later. Address 0 returns the low time word and address 1 returns the high time word.
- R5: Channel k's sample counter increases by one on each edge where smp_strobe[k] is high, independently of the other channels. Address 2+2k returns it, zero-extended to 32 bits.
- R6: A sample counter is MSC_W bits wide (default 32). It wraps from all ones to zero with no other effect.
- R7: A read of address 2+2k copies, at the same edge, the pre-edge low time word into channel k's stamp register. Address 3+2k returns that stamp, which then stays unchanged while time advances.
- R8: A channel's stamp register changes only when that channel's own sample counter is read. Reads of any other address leave it unchanged.
- R9: A strobe and a counter read at the same edge return the count from before the strobe. The stamp taken at that edge matches that count, and the increment shows on the next read.
- R10: Addresses at or above 2+2*NUM_CH read as zero. While rd_en is low, rd_data keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick_en | input | 1 | Lets the microsecond divider run |
| smp_strobe | input | NUM_CH | One pulse per transferred sample, one bit per channel |
| rd_en | input | 1 | Register read request |
| rd_addr | input | AW | Register read address |
| rd_data | output | 32 | Registered read data |

## Verification
The bound checker watches several rules on every cycle. A carry out of the low word always bumps the high word. The time base, the sample counters and rd_data hold when nothing drives them. Every counter read loads the stamp with the pre-edge low word. The stamp stays frozen whenever its own counter is not read. Unmapped reads return zero, and a counter at all ones goes to zero when strobed.

Only the directed scenarios can show certain end-to-end effects. They check the exact divider period and that a stamp read long after the snapshot still gives the old time. They also check that a strobe arriving with the read is counted on the following read, and that the reset values match UST_INIT.

// File: rtl/ts_pkg.sv
package ts_pkg;

    localparam int WORD_W = 32;
    localparam int UST_W  = 64;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } ust_t;

    // Register kinds seen by the read mux
    typedef enum logic [1:0] {
        RK_UST_LO = 2'd0,
        RK_UST_HI = 2'd1,
        RK_COUNT  = 2'd2,
        RK_STAMP  = 2'd3
    } reg_kind_e;

    function automatic int reg_count(input int nch);
        return 2 + 2 * nch;
    endfunction

    function automatic int reg_addr_w(input int nch);
        int w;
        w = $clog2(reg_count(nch));
        return (w < 1) ? 1 : w;
    endfunction

    function automatic int count_addr(input int ch);
        return 2 + 2 * ch;
    endfunction

    function automatic int stamp_addr(input int ch);
        return 3 + 2 * ch;
    endfunction

endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic pulse
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign pulse = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (pulse) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ts_ust_counter.sv
module ts_ust_counter
    import ts_pkg::*;
#(
    parameter logic [UST_W-1:0] INIT = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output ust_t ust
);
    ust_t ust_q;
    logic [WORD_W:0] lo_sum;

    assign lo_sum = {1'b0, ust_q.lo} + {{WORD_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            ust_q <= ust_t'(INIT);
        end else if (step) begin
            ust_q.lo <= lo_sum[WORD_W-1:0];
            if (lo_sum[WORD_W]) begin
                ust_q.hi <= ust_q.hi + 1'b1;
            end
        end
    end

    assign ust = ust_q;
endmodule

// File: rtl/ts_msc_lane.sv
module ts_msc_lane
    import ts_pkg::*;
#(
    parameter int MSC_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              snap,
    input  logic [WORD_W-1:0] time_lo,
    output logic [MSC_W-1:0]  count,
    output logic [WORD_W-1:0] stamp
);
    logic [MSC_W-1:0]  count_q;
    logic [WORD_W-1:0] stamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (strobe) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q <= '0;
        end else if (snap) begin
            stamp_q <= time_lo;
        end
    end

    assign count = count_q;
    assign stamp = stamp_q;
endmodule

// File: rtl/ts_stamp_unit.sv
module ts_stamp_unit
    import ts_pkg::*;
#(
    parameter int                CLK_PER_US = 250,
    parameter int                NUM_CH     = 2,
    parameter int                MSC_W      = 32,
    parameter logic [UST_W-1:0]  UST_INIT   = '0,
    localparam int               AW         = reg_addr_w(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick_en,
    input  logic [NUM_CH-1:0] smp_strobe,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic                           us_pulse;
    ust_t                           ust_w;
    logic [WORD_W-1:0]              ust_hi_w;
    logic [WORD_W-1:0]              ust_lo_w;
    logic [NUM_CH-1:0]              snap_w;
    logic [NUM_CH-1:0][MSC_W-1:0]   count_w;
    logic [NUM_CH-1:0][WORD_W-1:0]  stamp_w;
    logic [WORD_W-1:0]              rd_next;
    logic [WORD_W-1:0]              rd_q;
    reg_kind_e                      kind;
    logic                           hit;

    ts_prescaler #(.DIV(CLK_PER_US)) u_div (
        .clk   (clk),
        .rst   (rst),
        .en    (us_tick_en),
        .pulse (us_pulse)
    );

    ts_ust_counter #(.INIT(UST_INIT)) u_ust (
        .clk  (clk),
        .rst  (rst),
        .step (us_pulse),
        .ust  (ust_w)
    );

    assign ust_hi_w = ust_w.hi;
    assign ust_lo_w = ust_w.lo;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        assign snap_w[k] = rd_en && (rd_addr == AW'(count_addr(k)));

        ts_msc_lane #(.MSC_W(MSC_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .strobe  (smp_strobe[k]),
            .snap    (snap_w[k]),
            .time_lo (ust_lo_w),
            .count   (count_w[k]),
            .stamp   (stamp_w[k])
        );
    end

    // Read decode: pick kind and channel, then select data
    always_comb begin
        rd_next = '0;
        kind    = RK_UST_LO;
        hit     = 1'b0;
        if (rd_addr == AW'(0)) begin
            kind = RK_UST_LO;
            hit  = 1'b1;
            rd_next = ust_lo_w;
        end else if (rd_addr == AW'(1)) begin
            kind = RK_UST_HI;
            hit  = 1'b1;
            rd_next = ust_hi_w;
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_addr == AW'(count_addr(k))) begin
                kind    = RK_COUNT;
                hit     = 1'b1;
                rd_next = WORD_W'(count_w[k]);
            end
            if (rd_addr == AW'(stamp_addr(k))) begin
                kind    = RK_STAMP;
                hit     = 1'b1;
                rd_next = stamp_w[k];
            end
        end
        if (!hit) begin
            rd_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    logic unused_kind;
    assign unused_kind = ^kind;
endmodule

// File: rtl/ts_stamp_unit_chk.sv
module ts_stamp_unit_chk #(
    parameter int NUM_CH = 2,
    parameter int MSC_W  = 32,
    parameter int AW     = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          us_tick_en,
    input logic                          us_pulse,
    input logic [31:0]                   ust_hi,
    input logic [31:0]                   ust_lo,
    input logic [NUM_CH-1:0]             smp_strobe,
    input logic                          rd_en,
    input logic [AW-1:0]                 rd_addr,
    input logic [31:0]                   rd_data,
    input logic [NUM_CH-1:0][MSC_W-1:0]  count,
    input logic [NUM_CH-1:0][31:0]       stamp
);
    a_r2_time_hold: assert property (@(posedge clk) disable iff (rst)
        !us_tick_en |=> $stable({ust_hi, ust_lo}))
        else $error("R2 time base moved while divider disabled");

    a_r3_carry: assert property (@(posedge clk) disable iff (rst)
        (us_pulse && ust_lo == 32'hFFFF_FFFF) |=>
            (ust_lo == 32'd0 && ust_hi == $past(ust_hi) + 32'd1))
        else $error("R3 high word missed carry");

    a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data))
        else $error("R10 rd_data changed without a read");

    a_r10_unmapped: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(rd_addr) >= 2 + 2 * NUM_CH) |=> rd_data == 32'd0)
        else $error("R10 unmapped read not zero");

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
            !smp_strobe[k] |=> $stable(count[k]))
            else $error("R5 counter moved without strobe");

        a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
            (smp_strobe[k] && count[k] == {MSC_W{1'b1}}) |=> count[k] == '0)
            else $error("R6 counter did not wrap to zero");

        a_r7_capture: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == AW'(2 + 2 * k)) |=> stamp[k] == $past(ust_lo))
            else $error("R7 stamp not equal to pre-edge low word");

        a_r8_stamp_hold: assert property (@(posedge clk) disable iff (rst)
            !(rd_en && rd_addr == AW'(2 + 2 * k)) |=> $stable(stamp[k]))
            else $error("R8 stamp changed without its counter read");
    end
endmodule

bind ts_stamp_unit ts_stamp_unit_chk #(
    .NUM_CH (NUM_CH),
    .MSC_W  (MSC_W),
    .AW     (AW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .us_tick_en (us_tick_en),
    .us_pulse   (us_pulse),
    .ust_hi     (ust_hi_w),
    .ust_lo     (ust_lo_w),
    .smp_strobe (smp_strobe),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .count      (count_w),
    .stamp      (stamp_w)
);

// File: tb/ts_stamp_unit_tb_top.sv
module ts_stamp_unit_tb_top;
    localparam int          DIV    = 3;
    localparam int          NCH    = 2;
    localparam int          MW     = 8;
    localparam logic [63:0] INIT   = 64'h0000_0005_FFFF_FF00;
    localparam int          AW     = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick_en = 1'b0;
    logic [NCH-1:0] strobe = '0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic [31:0]    rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ts_stamp_unit #(
        .CLK_PER_US (DIV),
        .NUM_CH     (NCH),
        .MSC_W      (MW),
        .UST_INIT   (INIT)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .us_tick_en (tick_en),
        .smp_strobe (strobe),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    // Requirement model built from R1..R9
    int          m_div;
    logic [63:0] m_ust;
    logic [MW-1:0] m_cnt [NCH];
    logic [31:0] m_stamp [NCH];

    always @(posedge clk) begin
        if (rst) begin
            m_div <= 0;
            m_ust <= INIT;
            for (int k = 0; k < NCH; k++) begin
                m_cnt[k]   <= '0;
                m_stamp[k] <= '0;
            end
        end else begin
            if (tick_en) begin
                if (m_div == DIV - 1) begin
                    m_div <= 0;
                    m_ust <= m_ust + 64'd1;
                end else begin
                    m_div <= m_div + 1;
                end
            end
            for (int k = 0; k < NCH; k++) begin
                if (strobe[k]) m_cnt[k] <= m_cnt[k] + 1'b1;
                if (rd_en && int'(rd_addr) == 2 + 2 * k) m_stamp[k] <= m_ust[31:0];
            end
        end
    end

    function automatic logic [31:0] exp_for(input int a);
        case (a)
            0: return m_ust[31:0];
            1: return m_ust[63:32];
            2: return 32'(m_cnt[0]);
            3: return m_stamp[0];
            4: return 32'(m_cnt[1]);
            5: return m_stamp[1];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One read; optional strobe mask in the same cycle
    task automatic rd(input int a, input logic [NCH-1:0] smask, input string req,
                      output logic [31:0] val);
        logic [31:0] e;
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = AW'(a);
        strobe  = smask;
        e = exp_for(a);
        @(negedge clk);
        rd_en  = 1'b0;
        strobe = '0;
        val = rd_data;
        check(val, e, req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_strobes(input logic [NCH-1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            strobe = m;
        end
        @(negedge clk);
        strobe = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(rd_data, 32'd0, "R1 rd_data");
        rd(0, '0, "R1 low", v);  check(v, INIT[31:0], "R1 low init");
        rd(1, '0, "R1 high", v); check(v, INIT[63:32], "R1 high init");
        rd(2, '0, "R1 count0", v);
        rd(5, '0, "R1 stamp1", v);
    endtask

    task automatic t_divider;
        logic [31:0] a, b;
        rd(0, '0, "R2 start", a);
        idle(10);
        rd(0, '0, "R2 frozen", b);
        check(b, a, "R2 hold while disabled");
        @(negedge clk); tick_en = 1'b1;
        idle(4 * DIV - 1);
        @(negedge clk); tick_en = 1'b0;
        rd(0, '0, "R2 after run", b);
        check(b, a + 32'd4, "R2 four microseconds");
    endtask

    task automatic t_carry;
        logic [31:0] v;
        @(negedge clk); tick_en = 1'b1;
        idle(260 * DIV);
        @(negedge clk); tick_en = 1'b0;
        rd(1, '0, "R3 high after carry", v);
        check(v, INIT[63:32] + 32'd1, "R3 high incremented");
        rd(0, '0, "R4 low after carry", v);
    endtask

    task automatic t_counts;
        logic [31:0] v;
        pulse_strobes(2'b01, 5);
        pulse_strobes(2'b11, 3);
        rd(2, '0, "R5 count0", v); check(v, 32'd8, "R5 count0 value");
        rd(4, '0, "R5 count1", v); check(v, 32'd3, "R5 count1 value");
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        pulse_strobes(2'b10, 255);
        rd(4, '0, "R6 wrapped count1", v);
        check(v, 32'd2, "R6 wrap value");
    endtask

    task automatic t_snapshot;
        logic [31:0] lo, v;
        @(negedge clk); tick_en = 1'b0;
        rd(0, '0, "R7 live low", lo);
        rd(2, '0, "R7 count read", v);
        rd(3, '0, "R7 stamp", v); check(v, lo, "R7 stamp equals low");
        @(negedge clk); tick_en = 1'b1;
        idle(5 * DIV);
        @(negedge clk); tick_en = 1'b0;
        rd(0, '0, "R7 live moved", v);
        check(v, lo + 32'd5, "R7 time advanced");
        rd(3, '0, "R7 stamp frozen", v); check(v, lo, "R7 stamp unchanged");
    endtask

    task automatic t_other_reads;
        logic [31:0] s0, v;
        rd(3, '0, "R8 stamp0 before", s0);
        @(negedge clk); tick_en = 1'b1;
        rd(4, '0, "R8 count1", v);
        rd(0, '0, "R8 low", v);
        rd(5, '0, "R8 stamp1", v);
        rd(1, '0, "R8 high", v);
        @(negedge clk); tick_en = 1'b0;
        rd(3, '0, "R8 stamp0 after", v);
        check(v, s0, "R8 stamp0 untouched");
    endtask

    task automatic t_same_edge;
        logic [31:0] lo, c0, v;
        rd(0, '0, "R9 low", lo);
        rd(2, '0, "R9 count pre", c0);
        rd(2, 2'b01, "R9 count with strobe", v);
        check(v, c0, "R9 pre-strobe count");
        rd(3, '0, "R9 stamp", v); check(v, lo, "R9 stamp matches");
        rd(2, '0, "R9 count post", v);
        check(v, c0 + 32'd1, "R9 increment visible");
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        rd(7, '0, "R10 addr7", v); check(v, 32'd0, "R10 zero");
        rd(1, '0, "R10 prime", v);
        idle(3);
        check(rd_data, v, "R10 hold when idle");
        rd(6, '0, "R10 addr6", v); check(v, 32'd0, "R10 zero six");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_divider;
        t_carry;
        t_counts;
        t_wrap;
        t_snapshot;
        t_other_reads;
        t_same_edge;
        t_unmapped;
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule